// File: doc/BRIEF.md
# Delayed Transaction Discard Timer

This block guards one delayed-transaction slot in a bus bridge. When the completion data for a deferred read lands in the bridge buffer, the block starts counting bus clocks. It then waits for the original initiator to come back and retry. If the retry arrives in time, the count is dropped quietly. If it does not, the block emits a one-clock discard pulse so that the buffered entry can be freed. It also sets a sticky status bit.

The status bit is cleared by software writing a 1 to it. While the status bit is set and the error-enable input is high, a system-error output is driven toward the primary side. One select input picks between a long wait and a short wait. Its value is captured when counting begins.

Top module: `dt_discard_timer`

## Requirements
- R1: After reset, discardPulse, statusOut and sysErr are all 0.
- R2: With fastTimeout=0 when dataBuffered is sampled in the idle state, discardPulse is high in the cycle that follows the 2^15-th rising edge after the sampling edge, provided no retry is seen.
- R3: With fastTimeout=1 when dataBuffered is sampled, the discard follows the 2^10-th rising edge after the sampling edge.
- R4: A retrySeen sampled on any edge up to and including the expiry edge cancels the count. No discard follows, and statusOut is not set.
- R5: discardPulse lasts exactly one clock. After a discard or a cancel, no further discard occurs until dataBuffered is sampled again.
- R6: A discard sets statusOut to 1, and it holds there. A write (statusWrite=1) with statusWrData=1 clears it. A write with statusWrData=0 leaves it unchanged.
- R7: When a discard and a clearing write fall on the same edge, the set wins and statusOut is 1.
- R8: sysErr equals statusOut while errEnable=1, and sysErr is 0 while errEnable=0.
- R9: fastTimeout is captured only when counting starts. A change during a count does not alter that count's length.
- R10: dataBuffered sampled while a count is running is ignored. It neither restarts nor extends the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dataBuffered | input | 1 | Strobe: completion data now held in the buffer |
| retrySeen | input | 1 | Strobe: initiator repeated the request |
| fastTimeout | input | 1 | 0 selects 2^15 clocks, 1 selects 2^10 clocks |
| errEnable | input | 1 | Allows statusOut to drive sysErr |
| statusWrite | input | 1 | Status write strobe |
| statusWrData | input | 1 | Write data; 1 clears the status bit |
| discardPulse | output | 1 | One-clock pulse: drop the buffered transaction |
| sysErr | output | 1 | System-error indication toward the primary side |
| statusOut | output | 1 | Sticky discard status bit |

## Verification
The assertions check several rules on every cycle:
- the discard pulse is a single clock wide;
- every discard leaves the status bit set;
- the status bit stays put unless a clearing write arrives;
- a clearing write takes effect unless a discard lands on the same edge;
- sysErr never appears without both the status bit and the enable;
- a retry is never followed directly by a discard.

The exact length of each count can only be shown by the bench's scenarios. The same holds for the last-moment retry, the capture of the select bit at start, and the ignored extra data strobe. The bench checks these against discard times it computes for both timeout settings.

// File: rtl/dt_discard_pkg.sv
package dt_discard_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_COUNT = 1'b1
  } dtState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;  // begin a new count, capture select
    logic advance;    // count one more clock
    logic stop;       // return counter to zero
    logic setStatus;  // raise sticky status
  } dtStrobes_t;

endpackage

// File: rtl/dt_discard_ctrl.sv
module dt_discard_ctrl
  import dt_discard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dataBuffered,
  input  logic       retrySeen,
  input  logic       expired,
  output dtStrobes_t strobes,
  output logic       discardPulse
);

  dtState_t stateQ, stateD;
  logic     discardQ;

  always_comb begin
    strobes   = '0;
    stateD    = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (dataBuffered) begin
          strobes.loadStart = 1'b1;
          stateD            = ST_COUNT;
        end
      end
      ST_COUNT: begin
        if (retrySeen) begin
          strobes.stop = 1'b1;
          stateD       = ST_IDLE;
        end else if (expired) begin
          strobes.stop      = 1'b1;
          strobes.setStatus = 1'b1;
          stateD            = ST_IDLE;
        end else begin
          strobes.advance = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ   <= ST_IDLE;
      discardQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      discardQ <= strobes.setStatus;
    end
  end

  assign discardPulse = discardQ;

endmodule

// File: rtl/dt_discard_datapath.sv
module dt_discard_datapath
  import dt_discard_pkg::*;
#(
  parameter int LONG_EXP  = 15,
  parameter int SHORT_EXP = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  dtStrobes_t strobes,
  input  logic       fastTimeout,
  input  logic       errEnable,
  input  logic       statusWrite,
  input  logic       statusWrData,
  output logic       expired,
  output logic       statusOut,
  output logic       sysErr
);

  localparam int CNT_W = LONG_EXP;
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'((64'd1 << LONG_EXP) - 64'd1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'((64'd1 << SHORT_EXP) - 64'd1);

  logic [CNT_W-1:0] cntQ;
  logic             selFastQ;
  logic             statusQ;
  logic [CNT_W-1:0] lastValue;

  assign lastValue = selFastQ ? SHORT_LAST : LONG_LAST;
  assign expired   = (cntQ == lastValue);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntQ     <= '0;
      selFastQ <= 1'b0;
    end else begin
      if (strobes.loadStart) begin
        cntQ     <= '0;
        selFastQ <= fastTimeout;
      end else if (strobes.stop) begin
        cntQ <= '0;
      end else if (strobes.advance) begin
        cntQ <= cntQ + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         statusQ <= 1'b0;
    else if (strobes.setStatus)         statusQ <= 1'b1;
    else if (statusWrite && statusWrData) statusQ <= 1'b0;
  end

  assign statusOut = statusQ;
  assign sysErr    = statusQ & errEnable;

endmodule

// File: rtl/dt_discard_timer.sv
module dt_discard_timer
  import dt_discard_pkg::*;
#(
  parameter int LONG_EXP  = 15,
  parameter int SHORT_EXP = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dataBuffered,
  input  logic retrySeen,
  input  logic fastTimeout,
  input  logic errEnable,
  input  logic statusWrite,
  input  logic statusWrData,
  output logic discardPulse,
  output logic sysErr,
  output logic statusOut
);

  dtStrobes_t strobes;
  logic       expired;

  dt_discard_ctrl i_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .dataBuffered (dataBuffered),
    .retrySeen    (retrySeen),
    .expired      (expired),
    .strobes      (strobes),
    .discardPulse (discardPulse)
  );

  dt_discard_datapath #(
    .LONG_EXP  (LONG_EXP),
    .SHORT_EXP (SHORT_EXP)
  ) i_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .fastTimeout  (fastTimeout),
    .errEnable    (errEnable),
    .statusWrite  (statusWrite),
    .statusWrData (statusWrData),
    .expired      (expired),
    .statusOut    (statusOut),
    .sysErr       (sysErr)
  );

endmodule

// File: rtl/dt_discard_checker.sv
module dt_discard_checker (
  input logic clk,
  input logic rst_n,
  input logic dataBuffered,
  input logic retrySeen,
  input logic fastTimeout,
  input logic errEnable,
  input logic statusWrite,
  input logic statusWrData,
  input logic discardPulse,
  input logic sysErr,
  input logic statusOut
);

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    discardPulse |=> !discardPulse);

  assert_discard_sets_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    discardPulse |-> statusOut);

  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (statusOut && !(statusWrite && statusWrData)) |=> statusOut);

  assert_clear_or_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (statusWrite && statusWrData) |=> (!statusOut || discardPulse));

  assert_err_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sysErr |-> (statusOut && errEnable));

  assert_retry_cancels_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retrySeen |=> !discardPulse);

endmodule

bind dt_discard_timer dt_discard_checker i_chk (.*);

// File: tb/test_dt_discard_timer.sv
`timescale 1ns/1ps
module test_dt_discard_timer;

  localparam int LONG_T  = 1 << 15;
  localparam int SHORT_T = 1 << 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dataBuffered = 1'b0, retrySeen = 1'b0, fastTimeout = 1'b0, errEnable = 1'b0;
  logic statusWrite = 1'b0, statusWrData = 1'b0;
  logic discardPulse, sysErr, statusOut;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int expQ[$];

  always #2.5 clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 1;

  dt_discard_timer i_dt_discard_timer (
    .clk(clk), .rst_n(rst_n), .dataBuffered(dataBuffered), .retrySeen(retrySeen),
    .fastTimeout(fastTimeout), .errEnable(errEnable), .statusWrite(statusWrite),
    .statusWrData(statusWrData), .discardPulse(discardPulse), .sysErr(sysErr),
    .statusOut(statusOut)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at cyc %0d", req, act, exp, cyc);
    end
  endtask

  // monitor: every discard pulse must match the front of the scoreboard
  always @(negedge clk) begin
    if (rst_n && discardPulse === 1'b1) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R4/R5 unexpected discard actual=%0d expected=none", cyc);
      end else begin
        if (expQ[0] != cyc) begin
          fails++;
          $display("FAIL R2/R3 discard time actual=%0d expected=%0d", cyc, expQ[0]);
        end
        void'(expQ.pop_front());
      end
    end
  end

  task automatic goTo(int t);
    while (cyc < t) @(negedge clk);
  endtask

  // driver: one-cycle dataBuffered strobe; push expected discard time when needed
  task automatic startCount(logic fast, int limit, bit expect_discard, output int t0);
    fastTimeout  = fast;
    dataBuffered = 1'b1;
    t0 = cyc;
    if (expect_discard) expQ.push_back(t0 + 1 + limit);
    @(negedge clk);
    dataBuffered = 1'b0;
  endtask

  task automatic pulseRetry();
    retrySeen = 1'b1;
    @(negedge clk);
    retrySeen = 1'b0;
  endtask

  task automatic writeStatus(logic d);
    statusWrite = 1'b1; statusWrData = d;
    @(negedge clk);
    statusWrite = 1'b0; statusWrData = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    chk("R1 discard", discardPulse, 1'b0);
    chk("R1 status", statusOut, 1'b0);
    chk("R1 sysErr", sysErr, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 long timeout, error disabled
    startCount(1'b0, LONG_T, 1'b1, t0);
    goTo(t0 + 1 + LONG_T);
    chk("R2 pulse at expiry", discardPulse, 1'b1);
    @(negedge clk);
    chk("R5 pulse one clock", discardPulse, 1'b0);
    chk("R6 status set", statusOut, 1'b1);
    chk("R8 sysErr off when disabled", sysErr, 1'b0);
    errEnable = 1'b1; #0.1;
    chk("R8 sysErr follows status", sysErr, 1'b1);
    @(negedge clk);

    // R6 write 0 keeps, write 1 clears
    writeStatus(1'b0);
    chk("R6 write zero ignored", statusOut, 1'b1);
    writeStatus(1'b1);
    chk("R6 write one clears", statusOut, 1'b0);
    chk("R8 sysErr clears", sysErr, 1'b0);

    // R3 short timeout
    startCount(1'b1, SHORT_T, 1'b1, t0);
    goTo(t0 + 1 + SHORT_T);
    chk("R3 pulse at short expiry", discardPulse, 1'b1);
    @(negedge clk);
    writeStatus(1'b1);

    // R4 retry on the expiry edge cancels
    startCount(1'b1, SHORT_T, 1'b0, t0);
    goTo(t0 + SHORT_T);
    pulseRetry();
    goTo(t0 + SHORT_T + 50);
    chk("R4 no status after retry", statusOut, 1'b0);
    chk("R4 no discard after retry", discardPulse, 1'b0);

    // R5 stays idle: no discard without new data
    goTo(cyc + 3000);
    chk("R5 idle no discard", discardPulse, 1'b0);

    // R9 select changed mid-count: fast start, slow later
    startCount(1'b1, SHORT_T, 1'b1, t0);
    goTo(t0 + 100);
    fastTimeout = 1'b0;
    goTo(t0 + 1 + SHORT_T);
    chk("R9 short kept", discardPulse, 1'b1);
    @(negedge clk);
    writeStatus(1'b1);

    // R9 slow start, fast later
    startCount(1'b0, LONG_T, 1'b1, t0);
    goTo(t0 + 100);
    fastTimeout = 1'b1;
    goTo(t0 + 1 + SHORT_T + 5);
    chk("R9 no early short discard", statusOut, 1'b0);
    goTo(t0 + 1 + LONG_T);
    chk("R9 long kept", discardPulse, 1'b1);
    @(negedge clk);
    writeStatus(1'b1);

    // R10 extra dataBuffered during count ignored
    startCount(1'b1, SHORT_T, 1'b1, t0);
    goTo(t0 + 500);
    dataBuffered = 1'b1;
    @(negedge clk);
    dataBuffered = 1'b0;
    goTo(t0 + 1 + SHORT_T);
    chk("R10 original expiry kept", discardPulse, 1'b1);
    goTo(t0 + 600 + SHORT_T);
    chk("R10 no restarted discard", discardPulse, 1'b0);
    writeStatus(1'b1);

    // R7 clear on same edge as set
    startCount(1'b1, SHORT_T, 1'b1, t0);
    goTo(t0 + SHORT_T);
    writeStatus(1'b1);
    chk("R7 set wins", statusOut, 1'b1);
    @(negedge clk);
    chk("R7 status held", statusOut, 1'b1);

    repeat (20) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R2/R3 missing discards actual=%0d expected=0", expQ.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule